// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog timer with a byte-wide register port. A down-counter decrements on a clock-enable pulse. When it is ticked at zero it reloads and signals the event, either as a one-cycle interrupt pulse or as a one-cycle reset pulse. Software keeps the counter from running out with a two-write refresh: a write of 00h to the refresh register, followed by a write of FFh as the very next bus write.

A second control, the protection latch, hardens the watchdog. Software can only turn it on, using its own two-write sequence: a write with bit 7 clear, then a write with bit 7 set. Software can never turn it off. While the latch is set, the counter takes its ticks from a dedicated enable input rather than the main one, and every underflow becomes a reset. Two static option inputs set the power-up state of the latch and the reload value of the counter. The oscillator, the option storage and the processor are outside the block and reach it only as plain inputs.

Top module: `wdt_protected`

## Requirements
- R1: While `rstN` is low and at the first cycle after it, `count` equals the reload value, both pulse outputs are 0, and `protOn` equals the inverse of `optProtInitN`.
- R2: The reload value is 2^(CNT_W-4)-1, 2^(CNT_W-2)-1, 2^(CNT_W-1)-1 or 2^CNT_W-1 for `optUfSel` = 0, 1, 2 or 3.
- R3: Each cycle with the selected tick high decrements a nonzero `count` by one. The selected tick is `mainTick` when `protOn` is 0 and `wdtTick` when it is 1. The tick that is not selected has no effect on `count`.
- R4: A selected tick while `count` is 0 reloads the counter and drives a one-cycle pulse in the next cycle. The pulse is `wdtRst` when `protOn` or `swRstSel` is 1, and `wdtIrq` otherwise. The two pulses are never high together.
- R5: A write of FFh to the refresh register (offset 37Dh) reloads `count` when the previous bus write was 00h to that same register. Idle cycles and ticks between the two writes do not break the sequence. A refresh takes priority over a tick in the same cycle and produces no pulse.
- R6: A write of FFh to the refresh register has no effect on `count` when it is not preceded by 00h to that register, or when any other bus write comes in between.
- R7: A write with bit 7 set to the control register (offset 37Ch) sets `protOn` when the previous bus write was to the control register with bit 7 clear.
- R8: A lone write of bit 7 = 1 to the control register, or one that follows an unrelated write, leaves `protOn` at 0.
- R9: Once set, `protOn` stays 1 for any bus writes. Only `rstN` returns it to its power-up value.
- R10: A read of the control register returns `protOn` in bit 7 and 0 in bits 6 to 0. The refresh register and every other offset read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Write strobe, one bus write per high cycle |
| busAddr | input | ADDR_W | Register offset |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| mainTick | input | 1 | Main clock enable, used while protection is off |
| wdtTick | input | 1 | Dedicated watchdog clock enable, used while protection is on |
| swRstSel | input | 1 | Software choice of reset instead of interrupt on underflow |
| optUfSel | input | 2 | Static option that selects the reload value |
| optProtInitN | input | 1 | Static option, 0 starts the block with protection on |
| wdtIrq | output | 1 | One-cycle underflow interrupt pulse |
| wdtRst | output | 1 | One-cycle underflow reset pulse |
| protOn | output | 1 | State of the protection latch |
| count | output | CNT_W | Present counter value |

## Verification
The assertions assume that `optUfSel` and `optProtInitN` change only while `rstN` is low. They also assume CNT_W is at least 5, so the smallest reload is nonzero and two pulses cannot come back to back. The bench changes the option inputs only inside its reset task. It drives bus writes, ticks and `swRstSel` at the falling edge, one write per cycle, so every write the block sees is a whole cycle with stable address and data. The bench uses CNT_W = 6, which keeps every reload short enough to count down in full for each option setting and both power-up protection states.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from the control half to the counter half, valid for one cycle.
  typedef struct packed {
    logic refresh;   // completed 00h/FFh refresh sequence
    logic tick;      // selected count enable for this cycle
    logic rstMode;   // underflow produces reset rather than interrupt
  } wdtStrobes_t;

  localparam int unsigned SEL_COUNT = 4;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h37C,
  parameter logic [ADDR_W-1:0] REFR_ADDR = 10'h37D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              mainTick,
  input  logic              wdtTick,
  input  logic              swRstSel,
  input  logic              optProtInitN,
  output logic              protOn,
  output wdtStrobes_t       strobes
);

  localparam logic [7:0] REFR_FIRST  = 8'h00;
  localparam logic [7:0] REFR_SECOND = 8'hFF;
  localparam int unsigned PROT_BIT   = 7;

  logic hitCtrl;
  logic hitRefr;
  logic refrArmed;   // previous bus write was 00h to refresh register
  logic protArmed;   // previous bus write was control register with bit 7 clear
  logic protSet;
  logic refreshNow;

  assign hitCtrl = (busAddr == CTRL_ADDR);
  assign hitRefr = (busAddr == REFR_ADDR);

  assign refreshNow = busWrEn && hitRefr && (busWrData == REFR_SECOND) && refrArmed;
  assign protSet    = busWrEn && hitCtrl && busWrData[PROT_BIT] && protArmed;

  // Each bus write re-evaluates both arming flags, so any intervening write
  // (to any offset, with any value) aborts a sequence in progress.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refrArmed <= 1'b0;
      protArmed <= 1'b0;
    end else if (busWrEn) begin
      refrArmed <= hitRefr && (busWrData == REFR_FIRST);
      protArmed <= hitCtrl && !busWrData[PROT_BIT];
    end
  end

  // One-way latch: only reset lowers it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protOn <= ~optProtInitN;
    end else if (protSet) begin
      protOn <= 1'b1;
    end
  end

  always_comb begin
    busRdData = 8'h00;
    if (hitCtrl) begin
      busRdData[PROT_BIT] = protOn;
    end
  end

  always_comb begin
    strobes.refresh = refreshNow;
    strobes.tick    = protOn ? wdtTick : mainTick;
    strobes.rstMode = protOn | swRstSel;
  end

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       optUfSel,
  input  wdtStrobes_t      strobes,
  output logic [CNT_W-1:0] count,
  output logic             wdtIrq,
  output logic             wdtRst
);

  logic [CNT_W-1:0] reloadTab [SEL_COUNT];
  logic [CNT_W-1:0] reloadVal;
  logic             underflow;

  // Reload values are all-ones masks of four widths derived from CNT_W.
  for (genvar g = 0; g < SEL_COUNT; g++) begin : g_reload
    localparam int unsigned EXP = (g == 0) ? CNT_W - 4 :
                                  (g == 3) ? CNT_W     : CNT_W - 3 + g;
    assign reloadTab[g] = {CNT_W{1'b1}} >> (CNT_W - EXP);
  end

  assign reloadVal = reloadTab[optUfSel];
  assign underflow = strobes.tick && !strobes.refresh && (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= reloadVal;
    end else if (strobes.refresh) begin
      count <= reloadVal;
    end else if (strobes.tick) begin
      count <= (count == '0) ? reloadVal : count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtIrq <= 1'b0;
      wdtRst <= 1'b0;
    end else begin
      wdtIrq <= underflow && !strobes.rstMode;
      wdtRst <= underflow &&  strobes.rstMode;
    end
  end

endmodule

// File: rtl/wdt_protected.sv
module wdt_protected
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h37C,
  parameter logic [ADDR_W-1:0] REFR_ADDR = 10'h37D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              mainTick,
  input  logic              wdtTick,
  input  logic              swRstSel,
  input  logic [1:0]        optUfSel,
  input  logic              optProtInitN,
  output logic              wdtIrq,
  output logic              wdtRst,
  output logic              protOn,
  output logic [CNT_W-1:0]  count
);

  wdtStrobes_t strobes;

  wdt_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .REFR_ADDR(REFR_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .mainTick(mainTick),
    .wdtTick(wdtTick), .swRstSel(swRstSel), .optProtInitN(optProtInitN),
    .protOn(protOn), .strobes(strobes)
  );

  wdt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .optUfSel(optUfSel), .strobes(strobes),
    .count(count), .wdtIrq(wdtIrq), .wdtRst(wdtRst)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h37C
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWrData,
  input logic              mainTick,
  input logic              wdtTick,
  input logic              wdtIrq,
  input logic              wdtRst,
  input logic              protOn,
  input logic [CNT_W-1:0]  count
);

  logic pastValid;
  logic selTick;

  assign selTick = protOn ? wdtTick : mainTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assert_prot_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    protOn |=> protOn);

  assert_prot_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $rose(protOn) |->
      $past(busWrEn && (busAddr == CTRL_ADDR) && busWrData[7]));

  assert_pulse_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(wdtIrq && wdtRst));

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    wdtIrq |=> !wdtIrq);

  assert_rst_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |=> !wdtRst);

  assert_no_irq_protected_R4: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && protOn && $past(protOn) |-> !wdtIrq);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn && !selTick |=> $stable(count));

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn && selTick && (count != '0) |=> count == $past(count) - 1'b1);

endmodule

bind wdt_protected wdt_checker #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .mainTick(mainTick), .wdtTick(wdtTick),
  .wdtIrq(wdtIrq), .wdtRst(wdtRst), .protOn(protOn), .count(count)
);

// File: tb/tb_wdt_protected.sv
module tb_wdt_protected;

  localparam int CNT_W  = 6;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] CTRL = 10'h37C;
  localparam logic [ADDR_W-1:0] REFR = 10'h37D;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [7:0]        busWrData = '0;
  logic [7:0]        busRdData;
  logic              mainTick = 1'b0;
  logic              wdtTick = 1'b0;
  logic              swRstSel = 1'b0;
  logic [1:0]        optUfSel = 2'd0;
  logic              optProtInitN = 1'b1;
  logic              wdtIrq;
  logic              wdtRst;
  logic              protOn;
  logic [CNT_W-1:0]  count;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wdt_protected #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL), .REFR_ADDR(REFR)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .mainTick(mainTick),
    .wdtTick(wdtTick), .swRstSel(swRstSel), .optUfSel(optUfSel),
    .optProtInitN(optProtInitN), .wdtIrq(wdtIrq), .wdtRst(wdtRst),
    .protOn(protOn), .count(count)
  );

  function automatic int reloadOf(input int sel);
    int e;
    e = (sel == 0) ? CNT_W - 4 : (sel == 3) ? CNT_W : CNT_W - 3 + sel;
    return (1 << e) - 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic [1:0] sel, input logic initN);
    @(negedge clk);
    rstN = 1'b0;
    optUfSel = sel;
    optProtInitN = initN;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic tick(input bit useWdt);
    @(negedge clk);
    if (useWdt) wdtTick = 1'b1; else mainTick = 1'b1;
    @(negedge clk);
    wdtTick = 1'b0; mainTick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stimulus
    logic [7:0] rd;
    int r;
    int v;

    // Sweep every reload option under both power-up protection states.
    for (int pi = 0; pi < 2; pi++) begin
      for (int sel = 0; sel < 4; sel++) begin
        bit prot;
        prot = (pi == 1);
        r = reloadOf(sel);
        swRstSel = sel[0];
        doReset(sel[1:0], !prot);
        busRead(CTRL, rd);
        check(count == r, "R1/R2 reset count", count, r);
        check(protOn == prot, "R1 reset protOn", protOn, prot);
        check(rd == (prot ? 8'h80 : 8'h00), "R1/R10 reset ctrl read", rd, prot ? 8'h80 : 8'h00);
        check(!wdtIrq && !wdtRst, "R1 no pulse after reset", {wdtIrq, wdtRst}, 0);
        // The unselected tick must not move the counter.
        tick(!prot);
        check(count == r, "R3 unselected tick ignored", count, r);
        for (int k = 1; k <= r; k++) begin
          tick(prot);
          check(count == r - k, "R3 decrement", count, r - k);
        end
        tick(prot);
        check(count == r, "R4 reload on underflow", count, r);
        if (prot || swRstSel) begin
          check(wdtRst && !wdtIrq, "R4 reset pulse", {wdtIrq, wdtRst}, 1);
        end else begin
          check(wdtIrq && !wdtRst, "R4 interrupt pulse", {wdtIrq, wdtRst}, 2);
        end
        @(negedge clk);
        check(!wdtIrq && !wdtRst, "R4 pulse one cycle", {wdtIrq, wdtRst}, 0);
      end
    end

    // Refresh sequences, protection off, largest reload.
    swRstSel = 1'b0;
    doReset(2'd3, 1'b1);
    r = reloadOf(3);
    repeat (5) tick(0);
    check(count == r - 5, "R3 five ticks", count, r - 5);
    busWrite(REFR, 8'h00);
    busWrite(REFR, 8'hFF);
    check(count == r, "R5 refresh reload", count, r);

    repeat (3) tick(0);
    v = r - 3;
    busWrite(REFR, 8'hFF);
    check(count == v, "R6 lone FFh ignored", count, v);
    busWrite(REFR, 8'h00);
    busWrite(CTRL, 8'h00);
    busWrite(REFR, 8'hFF);
    check(count == v, "R6 other write aborts", count, v);
    busWrite(REFR, 8'h00);
    busWrite(REFR, 8'h01);
    busWrite(REFR, 8'hFF);
    check(count == v, "R6 wrong value aborts", count, v);
    busWrite(REFR, 8'h00);
    busWrite(10'h000, 8'h00);
    busWrite(REFR, 8'hFF);
    check(count == v, "R6 write elsewhere aborts", count, v);

    busWrite(REFR, 8'h00);
    tick(0);
    check(count == v - 1, "R3 tick between refresh writes", count, v - 1);
    busWrite(REFR, 8'hFF);
    check(count == r, "R5 ticks do not break refresh", count, r);

    tick(0); tick(0);
    busWrite(REFR, 8'h00);
    busWrite(REFR, 8'h00);
    busWrite(REFR, 8'hFF);
    check(count == r, "R5 repeated 00h rearms", count, r);

    // Refresh and tick on the same cycle at count 0: refresh wins, no pulse.
    while (count != 0) tick(0);
    busWrite(REFR, 8'h00);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = REFR; busWrData = 8'hFF; mainTick = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; mainTick = 1'b0;
    check(count == r, "R5 refresh beats tick", count, r);
    check(!wdtIrq && !wdtRst, "R5 refresh gives no pulse", {wdtIrq, wdtRst}, 0);

    // Read-back of other offsets.
    busRead(REFR, rd);
    check(rd == 8'h00, "R10 refresh reads zero", rd, 0);
    busRead(10'h155, rd);
    check(rd == 8'h00, "R10 other offset reads zero", rd, 0);

    // Protection latch sequences.
    busWrite(CTRL, 8'h80);
    check(protOn == 1'b0, "R8 lone set ignored", protOn, 0);
    busWrite(CTRL, 8'h00);
    busWrite(REFR, 8'h00);
    busWrite(CTRL, 8'h80);
    check(protOn == 1'b0, "R8 interrupted set ignored", protOn, 0);
    busWrite(CTRL, 8'h7F);
    busWrite(CTRL, 8'hFF);
    check(protOn == 1'b1, "R7 two-write set", protOn, 1);
    busRead(CTRL, rd);
    check(rd == 8'h80, "R10 ctrl read low bits zero", rd, 8'h80);
    busWrite(CTRL, 8'h00);
    busWrite(CTRL, 8'h7F);
    check(protOn == 1'b1, "R9 clear writes ignored", protOn, 1);

    // With protection on, main tick ignored, dedicated tick counts, reset on underflow.
    v = count;
    tick(0);
    check(count == v, "R3 main tick ignored when protected", count, v);
    tick(1);
    check(count == v - 1, "R3 dedicated tick counts", count, v - 1);
    while (count != 0) tick(1);
    tick(1);
    check(wdtRst && !wdtIrq, "R4 protection forces reset", {wdtIrq, wdtRst}, 1);
    check(count == r, "R4 reload after protected underflow", count, r);

    doReset(2'd3, 1'b1);
    check(protOn == 1'b0, "R9 reset clears latch", protOn, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule